// File: doc/BRIEF.md
# Dual-Channel Converter Data Front End

This block is the digital input stage that feeds two 12-bit current-steering converter cores. It takes the external data buses, write strobes and update ticks, captures the words, steers them into per-channel holding registers and hands each core a new word together with a one-cycle update strobe. The whole block runs on one system clock. Every external strobe and tick is sampled as a level, and its edges are detected against the previous sample.

A mode input picks one of two ways of using the pins. With `mode_dual` high, the two channels are fully independent. Each has its own bus, write strobe and update tick. With `mode_dual` low, the block runs interleaved. I and Q words arrive in turn on bus A, and `strb_a` is the shared write. `strb_b` becomes the I/Q select, `tick_a` becomes the shared update tick and `tick_b` becomes the pair-realign input. Bus B is unused. In this mode the update is applied on every second `tick_a` edge, and the realign input sets which edges those are.

Each channel also has a complementary code output for the negative current leg. A sleep input freezes the core words while the internal latches keep their contents.

Top module: `dualdac_front`

## Requirements
- R1: With `mode_dual` = 1, channel A (`strb_a`, `tick_a`, `din_a`) and channel B (`strb_b`, `tick_b`, `din_b`) act independently. Activity on one channel never changes the other channel's code or valid output.
- R2: In dual mode, a rising edge of a channel's write strobe captures its bus into that channel's input latch. A rising edge of its update tick copies the input latch to the core. When both edges fall on the same clock, the word latched before that clock is the one sent. A write with no update changes no output.
- R3: With `mode_dual` = 0, a rising edge of `strb_a` loads `din_a` into the I latch when `strb_b` = 1, or into the Q latch when `strb_b` = 0. The other latch keeps its value, and `din_b` is ignored.
- R4: In interleaved mode, the I and Q latches pass to a hold stage on the next falling edge of `strb_a`. An update loads both cores from the hold stage on the same clock, and `vld_a` and `vld_b` pulse together.
- R5: In interleaved mode, a core update happens on every second rising edge of `tick_a`. The first such edge after reset or after a realign produces an update.
- R6: In interleaved mode, while `tick_b` = 1 no update occurs and the update phase is cleared. The next `tick_a` rising edge with `tick_b` = 0 produces an update.
- R7: An update edge sampled at clock edge k makes the new code and a one-cycle valid pulse visible after edge k+3, which is 4 cycles counting edge k. Valid is low after edge k+2 and low again after edge k+4.
- R8: Codes are 12-bit straight offset binary with bit 11 as the MSB. `code_x_n` always equals 4095 minus `code_x`.
- R9: While `sleep` = 1, both valid outputs stay low and both codes hold. The input latches keep their contents, so an update after `sleep` returns to 0 sends the word written during sleep.
- R10: After synchronous reset, both codes are 0, both complements are 4095, both valids are 0, and the interleave update phase is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_dual | input | 1 | 1 = two independent channels, 0 = interleaved I/Q on bus A |
| sleep | input | 1 | 1 = freeze core outputs, 0 = normal operation |
| strb_a | input | 1 | Channel A write strobe, or the shared write in interleaved mode |
| strb_b | input | 1 | Channel B write strobe, or the I/Q select in interleaved mode (1 = I) |
| tick_a | input | 1 | Channel A update tick, or the shared update tick in interleaved mode |
| tick_b | input | 1 | Channel B update tick, or the pair-realign input in interleaved mode |
| din_a | input | 12 | Bus A data, offset binary |
| din_b | input | 12 | Bus B data, offset binary (dual mode only) |
| code_a | output | 12 | Core word, channel A / I |
| code_a_n | output | 12 | 4095 minus `code_a` |
| vld_a | output | 1 | One-cycle update strobe for channel A / I |
| code_b | output | 12 | Core word, channel B / Q |
| code_b_n | output | 12 | 4095 minus `code_b` |
| vld_b | output | 1 | One-cycle update strobe for channel B / Q |

## Verification
The hardest state to reach from the ports is the interleaved divider phase, because it is invisible until an update either happens or is skipped. The stimulus first runs one and then two `tick_a` edges to show the alternation. It then leaves the divider in its "next edge skips" phase and pulses `tick_a` with `tick_b` high. The edge that follows must update, which it would not do without the realign. Recirculation is exposed by rewriting only the I word and checking that Q is resent unchanged.

// File: rtl/dualdac_pkg.sv
package dualdac_pkg;

   // Pin-role selection: the level on mode_dual maps directly onto this.
   typedef enum logic {
      IF_INTERLEAVED = 1'b0,
      IF_DUAL        = 1'b1
   } if_mode_e;

endpackage

// File: rtl/dualdac_edge.sv
// Samples N level inputs on the system clock and flags either rising or
// falling transitions, chosen by a parameter.
module dualdac_edge #(
   parameter int N       = 1,
   parameter bit FALLING = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] hit
);

   logic [N-1:0] lvl_q;

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= '0;
      else     lvl_q <= lvl;
   end

   generate
      if (FALLING) begin : g_fall
         assign hit = lvl_q & ~lvl;
      end else begin : g_rise
         assign hit = lvl & ~lvl_q;
      end
   endgenerate

endmodule

// File: rtl/dualdac_steer.sv
// Input latches for both channels. In interleaved mode there is a select-
// driven load mux with recirculation (R3) and a hold stage loaded on the
// falling edge of the shared write (R4).
module dualdac_steer
   import dualdac_pkg::*;
#(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  if_mode_e     mode,
   input  logic [W-1:0] din_a,
   input  logic [W-1:0] din_b,
   input  logic         sel_i,
   input  logic         wr_rise_a,
   input  logic         wr_rise_b,
   input  logic         wr_fall_a,
   output logic [W-1:0] word_a,
   output logic [W-1:0] word_b
);

   logic [W-1:0] lat_i, lat_q;
   logic [W-1:0] hold_i, hold_q;
   logic [W-1:0] nxt_i, nxt_q;

   // Interleaved steering: the unselected latch feeds its own value back.
   always_comb begin
      nxt_i = (wr_rise_a &&  sel_i) ? din_a : lat_i;
      nxt_q = (wr_rise_a && !sel_i) ? din_a : lat_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lat_i  <= '0;
         lat_q  <= '0;
         hold_i <= '0;
         hold_q <= '0;
      end else if (mode == IF_DUAL) begin
         // R2: each channel's own write edge
         if (wr_rise_a) lat_i <= din_a;
         if (wr_rise_b) lat_q <= din_b;
      end else begin
         lat_i <= nxt_i;
         lat_q <= nxt_q;
         if (wr_fall_a) begin
            hold_i <= lat_i;
            hold_q <= lat_q;
         end
      end
   end

   assign word_a = (mode == IF_DUAL) ? lat_i : hold_i;
   assign word_b = (mode == IF_DUAL) ? lat_q : hold_q;

endmodule

// File: rtl/dualdac_updgen.sv
// Update enables. Dual mode gives one per channel tick edge. Interleaved mode
// divides tick_a by two, and tick_b forces the divider to its idle phase
// (R5, R6).
module dualdac_updgen
   import dualdac_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  if_mode_e mode,
   input  logic     tick_rise_a,
   input  logic     tick_rise_b,
   input  logic     realign,
   output logic     ev_a,
   output logic     ev_b
);

   logic div_q;
   logic ev_pair;

   always_ff @(posedge clk) begin
      if (rst)                                div_q <= 1'b0;
      else if (mode == IF_DUAL || realign)    div_q <= 1'b0;
      else if (tick_rise_a)                   div_q <= ~div_q;
   end

   // Pair update on the edge that moves the divider out of its idle phase.
   assign ev_pair = tick_rise_a & ~realign & ~div_q;

   assign ev_a = (mode == IF_DUAL) ? tick_rise_a : ev_pair;
   assign ev_b = (mode == IF_DUAL) ? tick_rise_b : ev_pair;

endmodule

// File: rtl/dualdac_outpipe.sv
// Per-channel core latch, delay line and sleep-gated output register.
// An update at edge k shows at the output after edge k+LATENCY-1 (R7, R9).
module dualdac_outpipe #(
   parameter int W       = 12,
   parameter int LATENCY = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         sleep,
   input  logic         ev,
   input  logic [W-1:0] word,
   output logic [W-1:0] code,
   output logic         vld
);

   localparam int DEPTH = LATENCY - 1;

   logic [DEPTH-1:0]        vpipe;
   logic [DEPTH-1:0][W-1:0] cpipe;
   logic                    take;

   assign take = vpipe[DEPTH-1] & ~sleep;

   always_ff @(posedge clk) begin
      if (rst) begin
         vpipe <= '0;
         cpipe <= '0;
         code  <= '0;
         vld   <= 1'b0;
      end else begin
         vpipe[0] <= ev;
         if (ev) cpipe[0] <= word;
         for (int i = 1; i < DEPTH; i++) begin
            vpipe[i] <= vpipe[i-1];
            cpipe[i] <= cpipe[i-1];
         end
         vld <= take;
         if (take) code <= cpipe[DEPTH-1];
      end
   end

endmodule

// File: rtl/dualdac_front.sv
// Top of the dual-channel converter data front end.
module dualdac_front
   import dualdac_pkg::*;
#(
   parameter int W       = 12,
   parameter int LATENCY = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         mode_dual,
   input  logic         sleep,
   input  logic         strb_a,
   input  logic         strb_b,
   input  logic         tick_a,
   input  logic         tick_b,
   input  logic [W-1:0] din_a,
   input  logic [W-1:0] din_b,
   output logic [W-1:0] code_a,
   output logic [W-1:0] code_a_n,
   output logic         vld_a,
   output logic [W-1:0] code_b,
   output logic [W-1:0] code_b_n,
   output logic         vld_b
);

   localparam int           NCH  = 2;
   localparam int           NEDG = 4;
   localparam logic [W-1:0] FULL = '1;

   generate
      if (W < 2 || W > 32) begin : g_bad_width
         $error("dualdac_front: W must lie in 2..32");
      end
      if (LATENCY < 2) begin : g_bad_latency
         $error("dualdac_front: LATENCY must be at least 2");
      end
   endgenerate

   if_mode_e          mode;
   logic [NEDG-1:0]   rise;
   logic              fall_wr;
   logic              ev_a, ev_b;
   logic [W-1:0]      word_a, word_b;
   logic [NCH-1:0]    ev_ch;
   logic [W-1:0]      word_ch [NCH];
   logic [W-1:0]      code_ch [NCH];
   logic [NCH-1:0]    vld_ch;

   assign mode = if_mode_e'(mode_dual);

   // Edge order in rise: 0 strb_a, 1 strb_b, 2 tick_a, 3 tick_b
   dualdac_edge #(.N(NEDG), .FALLING(1'b0)) u_rise (
      .clk (clk),
      .rst (rst),
      .lvl ({tick_b, tick_a, strb_b, strb_a}),
      .hit (rise)
   );

   dualdac_edge #(.N(1), .FALLING(1'b1)) u_fall (
      .clk (clk),
      .rst (rst),
      .lvl (strb_a),
      .hit (fall_wr)
   );

   dualdac_steer #(.W(W)) u_steer (
      .clk       (clk),
      .rst       (rst),
      .mode      (mode),
      .din_a     (din_a),
      .din_b     (din_b),
      .sel_i     (strb_b),
      .wr_rise_a (rise[0]),
      .wr_rise_b (rise[1]),
      .wr_fall_a (fall_wr),
      .word_a    (word_a),
      .word_b    (word_b)
   );

   dualdac_updgen u_updgen (
      .clk         (clk),
      .rst         (rst),
      .mode        (mode),
      .tick_rise_a (rise[2]),
      .tick_rise_b (rise[3]),
      .realign     (tick_b),
      .ev_a        (ev_a),
      .ev_b        (ev_b)
   );

   assign ev_ch      = {ev_b, ev_a};
   assign word_ch[0] = word_a;
   assign word_ch[1] = word_b;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         dualdac_outpipe #(.W(W), .LATENCY(LATENCY)) u_pipe (
            .clk   (clk),
            .rst   (rst),
            .sleep (sleep),
            .ev    (ev_ch[c]),
            .word  (word_ch[c]),
            .code  (code_ch[c]),
            .vld   (vld_ch[c])
         );
      end
   endgenerate

   assign code_a = code_ch[0];
   assign code_b = code_ch[1];
   assign vld_a  = vld_ch[0];
   assign vld_b  = vld_ch[1];

   // R8: complementary leg codes
   assign code_a_n = FULL - code_a;
   assign code_b_n = FULL - code_b;

endmodule

// File: rtl/dualdac_front_chk.sv
module dualdac_front_chk #(
   parameter int W = 12
) (
   input logic         clk,
   input logic         rst,
   input logic         mode_dual,
   input logic         sleep,
   input logic         tick_b,
   input logic [W-1:0] code_a,
   input logic [W-1:0] code_b,
   input logic         vld_a,
   input logic         vld_b,
   input logic         ev_a,
   input logic         ev_b
);

   AST_SLEEP_NO_VALID: assert property (@(posedge clk) disable iff (rst)
      sleep |=> (!vld_a && !vld_b)); // R9

   AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
      sleep |=> ($stable(code_a) && $stable(code_b))); // R9

   AST_CODE_A_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
      !$stable(code_a) |-> vld_a); // R7

   AST_CODE_B_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
      !$stable(code_b) |-> vld_b); // R7

   AST_REALIGN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (!mode_dual && tick_b) |-> (!ev_a && !ev_b)); // R6

   AST_PAIR_TOGETHER: assert property (@(posedge clk) disable iff (rst)
      !mode_dual |-> (ev_a == ev_b)); // R4

endmodule

bind dualdac_front dualdac_front_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .mode_dual (mode_dual),
   .sleep     (sleep),
   .tick_b    (tick_b),
   .code_a    (code_a),
   .code_b    (code_b),
   .vld_a     (vld_a),
   .vld_b     (vld_b),
   .ev_a      (ev_a),
   .ev_b      (ev_b)
);

// File: tb/dualdac_front_tb.sv
`timescale 1ns/1ps
module dualdac_front_tb;

   localparam int W  = 12;
   localparam int NV = 6;
   // Each entry: {din_a, din_b}
   localparam logic [23:0] VEC [NV] = '{
      24'h000FFF, 24'hFFF000, 24'h7FF800,
      24'h800001, 24'hA5C3AA, 24'h3C9F3F
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mode_dual = 1'b1, sleep = 1'b0;
   logic strb_a = 1'b0, strb_b = 1'b0, tick_a = 1'b0, tick_b = 1'b0;
   logic [W-1:0] din_a = '0, din_b = '0;
   logic [W-1:0] code_a, code_a_n, code_b, code_b_n;
   logic vld_a, vld_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dualdac_front u_dut (
      .clk(clk), .rst(rst), .mode_dual(mode_dual), .sleep(sleep),
      .strb_a(strb_a), .strb_b(strb_b), .tick_a(tick_a), .tick_b(tick_b),
      .din_a(din_a), .din_b(din_b),
      .code_a(code_a), .code_a_n(code_a_n), .vld_a(vld_a),
      .code_b(code_b), .code_b_n(code_b_n), .vld_b(vld_b)
   );

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_codes(input string req, input int ea, input int eb);
      chk(req, "code_a", int'(code_a), ea);
      chk(req, "code_b", int'(code_b), eb);
      chk("R8", "code_a+code_a_n", int'(code_a) + int'(code_a_n), 4095);
      chk("R8", "code_b+code_b_n", int'(code_b) + int'(code_b_n), 4095);
   endtask

   // Write-strobe pulse: high for one cycle, then low for one cycle
   task automatic wr_pulse(input logic wa, input logic wb);
      strb_a = wa; strb_b = wb; cyc();
      strb_a = 1'b0; if (mode_dual) strb_b = 1'b0; cyc();
   endtask

   // Update pulse sampled at edge k; returns at the negedge after k+2 with
   // the early-valid check done. The caller then runs cyc() once more to
   // look after k+3.
   task automatic upd_seq(input logic ta, input logic tb);
      tick_a = ta; tick_b = tb; cyc();
      tick_a = 1'b0; tick_b = 1'b0; cyc(); cyc();
      chk("R7", "vld_a early", int'(vld_a), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [W-1:0] last_b;
      repeat (3) cyc();
      rst = 1'b0;
      cyc();
      // R10 reset state
      chk_codes("R10", 0, 0);
      chk("R10", "code_a_n", int'(code_a_n), 4095);
      chk("R10", "vld_a", int'(vld_a), 0);
      chk("R10", "vld_b", int'(vld_b), 0);

      // R2 / R7 / R8: dual-mode vector walk
      mode_dual = 1'b1;
      for (int v = 0; v < NV; v++) begin
         din_a = VEC[v][23:12];
         din_b = VEC[v][11:0];
         wr_pulse(1'b1, 1'b1);
         upd_seq(1'b1, 1'b1);
         cyc();
         chk("R7", "vld_a", int'(vld_a), 1);
         chk("R7", "vld_b", int'(vld_b), 1);
         chk_codes("R2", int'(VEC[v][23:12]), int'(VEC[v][11:0]));
         cyc();
         chk("R7", "vld_a pulse end", int'(vld_a), 0);
      end
      last_b = VEC[NV-1][11:0];

      // R1: channel A alone
      din_a = 12'h111; din_b = 12'hEEE;
      wr_pulse(1'b1, 1'b0);
      upd_seq(1'b1, 1'b0);
      cyc();
      chk("R1", "vld_b", int'(vld_b), 0);
      chk_codes("R1", 'h111, int'(last_b));

      // R2: write and update on the same edge send the older word
      din_a = 12'h222;
      strb_a = 1'b1; tick_a = 1'b1; cyc();
      strb_a = 1'b0; tick_a = 1'b0; cyc(); cyc(); cyc();
      chk("R2", "vld_a same edge", int'(vld_a), 1);
      chk_codes("R2", 'h111, int'(last_b));
      upd_seq(1'b1, 1'b0);
      cyc();
      chk_codes("R2", 'h222, int'(last_b));

      // R2: a write with no update changes nothing
      din_a = 12'h333;
      wr_pulse(1'b1, 1'b0);
      repeat (5) cyc();
      chk("R2", "vld_a no update", int'(vld_a), 0);
      chk_codes("R2", 'h222, int'(last_b));

      // Interleaved mode
      mode_dual = 1'b0; cyc();
      din_b = 12'hABC;
      din_a = 12'h123; wr_pulse(1'b1, 1'b1);  // I word
      din_a = 12'h456; wr_pulse(1'b1, 1'b0);  // Q word
      upd_seq(1'b1, 1'b0);
      cyc();
      chk("R4", "vld_a", int'(vld_a), 1);
      chk("R4", "vld_b", int'(vld_b), 1);
      chk_codes("R3", 'h123, 'h456);

      // R5: the second tick_a edge skips
      upd_seq(1'b1, 1'b0);
      cyc();
      chk("R5", "vld_a second tick", int'(vld_a), 0);
      chk("R5", "vld_b second tick", int'(vld_b), 0);

      // R3: rewrite only I; Q recirculates; third edge updates
      strb_b = 1'b1;
      din_a = 12'h789; wr_pulse(1'b1, 1'b1);
      upd_seq(1'b1, 1'b0);
      cyc();
      chk("R5", "vld_a third tick", int'(vld_a), 1);
      chk_codes("R3", 'h789, 'h456);

      // R6: realign held high blocks updates and clears the phase
      upd_seq(1'b1, 1'b1);
      cyc();
      chk("R6", "vld_a under realign", int'(vld_a), 0);
      upd_seq(1'b1, 1'b1);
      cyc();
      chk("R6", "vld_b under realign", int'(vld_b), 0);
      upd_seq(1'b1, 1'b0);
      cyc();
      chk("R6", "vld_a after realign", int'(vld_a), 1);
      chk_codes("R6", 'h789, 'h456);

      // R9: sleep
      mode_dual = 1'b1; strb_b = 1'b0; cyc();
      sleep = 1'b1;
      din_a = 12'h5A5;
      wr_pulse(1'b1, 1'b0);
      upd_seq(1'b1, 1'b0);
      cyc();
      chk("R9", "vld_a asleep", int'(vld_a), 0);
      chk_codes("R9", 'h789, 'h456);
      sleep = 1'b0; cyc();
      upd_seq(1'b1, 1'b0);
      cyc();
      chk("R9", "vld_a awake", int'(vld_a), 1);
      chk_codes("R9", 'h5A5, 'h456);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule